// File: doc/BRIEF.md
# Packet-to-Flit Injector with Multicast

This block sits between a tile-side user and the local mesh router. The user hands over a complete packet in one cycle: a data body, a flag that says whether the body is meaningful, a message class, an intra-tile unit selector and a mask of destination tiles. The packet waits in a small internal queue. From the queue head the block cuts the packet into flits of the router's payload width. Every flit carries the virtual channel chosen by the message class, the destination coordinate and the unit selector.

A packet addressed to several tiles is sent again for each of them as a complete unicast flit sequence. Destinations are taken in round-robin order from a pending mask. A served mask records which destinations are finished, and the packet leaves the queue only when every requested destination has been sent. The router can stop any virtual channel with a per-channel off signal. While that signal is high no flit is offered on the channel and the sequence holds its place.

A build-time switch selects how a destination index becomes a coordinate. It is either read from a per-packet coordinate list or split directly into x and y bits.

Top module: `pkt_flit_injector`

## Requirements
- R1: A packet whose has-data flag is 0 produces exactly one flit per destination, of kind HT (code 3), whose payload is body bits [PAYLOAD_W-1:0].
- R2: A packet whose has-data flag is 1 produces NFLIT = ceil(BODY_W/PAYLOAD_W) flits per destination, with kinds HEAD (0), BODY (1) in the middle and TAIL (2) last. Flit i carries body bits [i*PAYLOAD_W +: PAYLOAD_W], and bits above BODY_W read as zero. When NFLIT is 1 the single flit is HT.
- R3: Every flit of a packet carries the same virtual channel and unit fields. The channel follows the class code: request 0 gives VC 0, response 1 gives VC 1, forward 2 gives VC 2 and service 3 gives VC 3. The unit field is copied from the packet.
- R4: Each set bit of the destination mask yields one complete flit sequence, and sequences never interleave. The next destination is the first pending index at or after a pointer. The pointer is 0 after reset, becomes the last served index plus one (modulo NDEST) and carries over between packets.
- R5: With IDX_MODE=0, destination i takes its coordinate from in_dest_list bits [i*(X_W+Y_W) +: X_W+Y_W], with y in the upper Y_W bits and x in the lower X_W bits.
- R6: With IDX_MODE=1, destination i is sent to x = i[X_W-1:0] and y = i[X_W +: Y_W].
- R7: out_valid stays 0 while vc_off is high for the packet's channel. Kind, payload and destination do not change during such a stall, and the sequence resumes where it stopped. An off signal on another channel has no effect.
- R8: One flit leaves per unblocked cycle. A packet accepted into an empty queue shows its first flit in the next cycle. The next packet's first flit follows in the cycle after the previous packet's last flit.
- R9: A packet with an all-zero destination mask emits no flit and leaves the queue after one cycle at its head.
- R10: in_full is 1 exactly when DEPTH packets are held. A packet offered while in_full is 1 is not accepted and never appears at the output, even when the head leaves in that same cycle.
- R11: During reset out_valid and in_full are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | User offers a packet this cycle |
| in_has_data | input | 1 | Packet body is meaningful (multi-flit) |
| in_class | input | 2 | Message class, selects the virtual channel |
| in_unit | input | UNIT_W | Intra-tile unit selector copied into every flit |
| in_dest_mask | input | NDEST | One bit per destination to reach |
| in_dest_list | input | NDEST*(X_W+Y_W) | Per-destination coordinates, used when IDX_MODE=0 |
| in_body | input | BODY_W | Packet body |
| in_full | output | 1 | Queue holds DEPTH packets, offers are refused |
| vc_off | input | NVC | Per-channel stop from the router |
| out_valid | output | 1 | A flit is presented to the router |
| out_kind | output | 2 | Flit kind: HEAD 0, BODY 1, TAIL 2, HT 3 |
| out_vc | output | log2(NVC) | Virtual channel of the flit |
| out_x | output | X_W | Destination x coordinate |
| out_y | output | Y_W | Destination y coordinate |
| out_unit | output | UNIT_W | Intra-tile unit selector |
| out_payload | output | PAYLOAD_W | Flit payload slice |

## Verification
Two events collide in one cycle: the queue head leaves after its last flit, and the user offers a new packet. The bench brings this about by stopping all channels until the queue is full, keeping in_valid high, and then releasing the channels. The offer in the cycle of the pop must be refused, and the offer one cycle later must be accepted. A cycle-accurate queue model in the bench predicts which offered packets reach the output, so a wrongly accepted packet shows up as extra or misplaced flits. The same bench also drops a stall onto the last flit of a destination, so the round-robin advance and the back-pressure hold must be resolved in the same cycle.

// File: rtl/inj_pkg.sv
package inj_pkg;

  typedef enum logic [1:0] {
    FK_HEAD = 2'd0,
    FK_BODY = 2'd1,
    FK_TAIL = 2'd2,
    FK_HT   = 2'd3
  } flit_kind_e;

  typedef enum logic [1:0] {
    CLS_REQ = 2'd0,
    CLS_RSP = 2'd1,
    CLS_FWD = 2'd2,
    CLS_SVC = 2'd3
  } msg_class_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic logic [1:0] class_vc(input logic [1:0] cls);
    logic [1:0] vc;
    case (cls)
      CLS_REQ: vc = 2'd0;
      CLS_RSP: vc = 2'd1;
      CLS_FWD: vc = 2'd2;
      default: vc = 2'd3;
    endcase
    return vc;
  endfunction

endpackage

// File: rtl/inj_pkt_queue.sv
module inj_pkt_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/inj_rr_pick.sv
module inj_rr_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [N-1:0]  grant_oh,
  output logic [IW-1:0] grant_idx
);
  logic [IW-1:0] ptr;
  logic          hit;
  int            slot;

  always_comb begin
    grant_oh  = '0;
    grant_idx = '0;
    hit       = 1'b0;
    slot      = 0;
    for (int k = 0; k < N; k++) begin
      slot = (int'(ptr) + k) % N;
      if (!hit && req[slot]) begin
        hit             = 1'b1;
        grant_oh[slot]  = 1'b1;
        grant_idx       = IW'(slot);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= (int'(grant_idx) == N - 1) ? '0 : grant_idx + 1'b1;
    end
  end
endmodule

// File: rtl/inj_flit_seq.sv
module inj_flit_seq
  import inj_pkg::*;
#(
  parameter int NFLIT = 3,
  parameter int NDEST = 4,
  parameter int FI_W  = (NFLIT > 1) ? $clog2(NFLIT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_valid,
  input  logic             has_data,
  input  logic [NDEST-1:0] dest_mask,
  input  logic [NDEST-1:0] grant_oh,
  input  logic             vc_blocked,
  output logic [NDEST-1:0] pending,
  output logic             fire,
  output flit_kind_e       kind,
  output logic [FI_W-1:0]  chunk_idx,
  output logic             dest_done,
  output logic             pkt_done
);
  logic [NDEST-1:0] served;
  logic [FI_W-1:0]  idx;
  logic             single, last, any_pending;

  assign pending     = head_valid ? (dest_mask & ~served) : '0;
  assign any_pending = |pending;
  assign single      = !has_data || (NFLIT == 1);
  assign last        = single || (idx == FI_W'(NFLIT - 1));
  assign fire        = any_pending && !vc_blocked;
  assign dest_done   = fire && last;
  assign pkt_done    = head_valid &&
                       (!any_pending || (dest_done && ((pending & ~grant_oh) == '0)));
  assign chunk_idx   = single ? '0 : idx;

  always_comb begin
    if (single)          kind = FK_HT;
    else if (idx == '0)  kind = FK_HEAD;
    else if (last)       kind = FK_TAIL;
    else                 kind = FK_BODY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      served <= '0;
      idx    <= '0;
    end else if (pkt_done) begin
      served <= '0;
      idx    <= '0;
    end else if (dest_done) begin
      served <= served | grant_oh;
      idx    <= '0;
    end else if (fire) begin
      idx    <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/pkt_flit_injector.sv
module pkt_flit_injector
  import inj_pkg::*;
#(
  parameter int BODY_W    = 40,
  parameter int PAYLOAD_W = 16,
  parameter int NDEST     = 4,
  parameter int X_W       = 2,
  parameter int Y_W       = 2,
  parameter int UNIT_W    = 2,
  parameter int DEPTH     = 4,
  parameter int IDX_MODE  = 0,
  parameter int NVC       = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         in_has_data,
  input  logic [1:0]                   in_class,
  input  logic [UNIT_W-1:0]            in_unit,
  input  logic [NDEST-1:0]             in_dest_mask,
  input  logic [NDEST*(X_W+Y_W)-1:0]   in_dest_list,
  input  logic [BODY_W-1:0]            in_body,
  output logic                         in_full,
  input  logic [NVC-1:0]               vc_off,
  output logic                         out_valid,
  output logic [1:0]                   out_kind,
  output logic [$clog2(NVC)-1:0]       out_vc,
  output logic [X_W-1:0]               out_x,
  output logic [Y_W-1:0]               out_y,
  output logic [UNIT_W-1:0]            out_unit,
  output logic [PAYLOAD_W-1:0]         out_payload
);
  localparam int NFLIT    = ceil_div(BODY_W, PAYLOAD_W);
  localparam int PAD_W    = NFLIT * PAYLOAD_W;
  localparam int FI_W     = (NFLIT > 1) ? $clog2(NFLIT) : 1;
  localparam int COORD_W  = X_W + Y_W;
  localparam int LIST_W   = NDEST * COORD_W;
  localparam int IDX_W    = (NDEST > 1) ? $clog2(NDEST) : 1;
  localparam int VC_W     = $clog2(NVC);
  localparam int OFF_LIST = BODY_W;
  localparam int OFF_MASK = OFF_LIST + LIST_W;
  localparam int OFF_UNIT = OFF_MASK + NDEST;
  localparam int OFF_CLS  = OFF_UNIT + UNIT_W;
  localparam int OFF_HD   = OFF_CLS + 2;
  localparam int REC_W    = OFF_HD + 1;

  // Named internal events (observed by the bound checker)
  logic               q_push, q_pop, q_empty, q_full;
  logic               head_valid, head_has_data;
  logic [REC_W-1:0]   rec_in, rec_head;
  logic [1:0]         head_cls;
  logic [UNIT_W-1:0]  head_unit;
  logic [NDEST-1:0]   head_mask;
  logic [LIST_W-1:0]  head_list;
  logic [BODY_W-1:0]  head_body;
  logic [VC_W-1:0]    head_vc;
  logic [NDEST-1:0]   pending, grant_oh;
  logic [IDX_W-1:0]   grant_idx;
  logic               flit_fire, dest_done, pkt_done, vc_blocked, stalled;
  flit_kind_e         kind;
  logic [FI_W-1:0]    chunk_idx;

  function automatic logic [PAYLOAD_W-1:0] pick_chunk(input logic [BODY_W-1:0] body,
                                                      input logic [FI_W-1:0]   k);
    logic [PAD_W-1:0] padded;
    padded = PAD_W'(body);
    return padded[int'(k)*PAYLOAD_W +: PAYLOAD_W];
  endfunction

  assign rec_in = {in_has_data, in_class, in_unit, in_dest_mask, in_dest_list, in_body};
  assign q_push = in_valid && !q_full;
  assign q_pop  = pkt_done;

  inj_pkt_queue #(.W(REC_W), .DEPTH(DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .din   (rec_in),
    .pop   (q_pop),
    .dout  (rec_head),
    .empty (q_empty),
    .full  (q_full)
  );

  assign head_valid    = !q_empty;
  assign head_has_data = rec_head[OFF_HD];
  assign head_cls      = rec_head[OFF_CLS +: 2];
  assign head_unit     = rec_head[OFF_UNIT +: UNIT_W];
  assign head_mask     = rec_head[OFF_MASK +: NDEST];
  assign head_list     = rec_head[OFF_LIST +: LIST_W];
  assign head_body     = rec_head[0 +: BODY_W];
  assign head_vc       = VC_W'(class_vc(head_cls));
  assign vc_blocked    = vc_off[head_vc];
  assign stalled       = head_valid && (|pending) && vc_blocked;

  inj_rr_pick #(.N(NDEST), .IW(IDX_W)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (pending),
    .advance   (dest_done),
    .grant_oh  (grant_oh),
    .grant_idx (grant_idx)
  );

  inj_flit_seq #(.NFLIT(NFLIT), .NDEST(NDEST), .FI_W(FI_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (head_valid),
    .has_data   (head_has_data),
    .dest_mask  (head_mask),
    .grant_oh   (grant_oh),
    .vc_blocked (vc_blocked),
    .pending    (pending),
    .fire       (flit_fire),
    .kind       (kind),
    .chunk_idx  (chunk_idx),
    .dest_done  (dest_done),
    .pkt_done   (pkt_done)
  );

  generate
    if (IDX_MODE != 0) begin : g_index_coord
      localparam int GW = (IDX_W > COORD_W) ? IDX_W : COORD_W;
      logic [GW-1:0] gwide;
      assign gwide = GW'(grant_idx);
      assign out_x = gwide[X_W-1:0];
      assign out_y = gwide[X_W +: Y_W];
    end else begin : g_list_coord
      logic [COORD_W-1:0] entry;
      assign entry = head_list[int'(grant_idx)*COORD_W +: COORD_W];
      assign out_x = entry[X_W-1:0];
      assign out_y = entry[COORD_W-1 -: Y_W];
    end
  endgenerate

  assign in_full     = q_full;
  assign out_valid   = flit_fire;
  assign out_kind    = kind;
  assign out_vc      = head_vc;
  assign out_unit    = head_unit;
  assign out_payload = pick_chunk(head_body, chunk_idx);
endmodule

// File: rtl/inj_checker.sv
module inj_checker #(
  parameter int NDEST  = 4,
  parameter int NVC    = 4,
  parameter int X_W    = 2,
  parameter int Y_W    = 2,
  parameter int PAY_W  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   out_valid,
  input logic [1:0]             out_kind,
  input logic [$clog2(NVC)-1:0] out_vc,
  input logic [X_W-1:0]         out_x,
  input logic [Y_W-1:0]         out_y,
  input logic [PAY_W-1:0]       out_payload,
  input logic [NVC-1:0]         vc_off,
  input logic                   in_full,
  input logic                   q_push,
  input logic                   head_has_data,
  input logic [NDEST-1:0]       grant_oh,
  input logic                   stalled
);
  AST_OFF_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !vc_off[out_vc]); // R7

  AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> ($stable(out_kind) && $stable(out_payload) && $stable(out_x) && $stable(out_y))); // R7

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    in_full |-> !q_push); // R10

  AST_NODATA_HT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !head_has_data) |-> (out_kind == 2'd3)); // R1

  AST_END_THEN_START: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_kind == 2'd2 || out_kind == 2'd3)) |=>
      (!out_valid || out_kind == 2'd0 || out_kind == 2'd3)); // R4

  AST_OPEN_THEN_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_kind == 2'd0 || out_kind == 2'd1)) |=>
      (!out_valid || out_kind == 2'd1 || out_kind == 2'd2)); // R2

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh)); // R4
endmodule

bind pkt_flit_injector inj_checker #(
  .NDEST (NDEST),
  .NVC   (NVC),
  .X_W   (X_W),
  .Y_W   (Y_W),
  .PAY_W (PAYLOAD_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .out_valid     (out_valid),
  .out_kind      (out_kind),
  .out_vc        (out_vc),
  .out_x         (out_x),
  .out_y         (out_y),
  .out_payload   (out_payload),
  .vc_off        (vc_off),
  .in_full       (in_full),
  .q_push        (q_push),
  .head_has_data (head_has_data),
  .grant_oh      (grant_oh),
  .stalled       (stalled)
);

// File: tb/sim_inj_lane.sv
module sim_inj_lane #(
  parameter int IDX_MODE = 0,
  parameter int NDEST    = 4,
  parameter int X_W      = 2,
  parameter int Y_W      = 2,
  parameter int BODY_W   = 40,
  parameter int SEED     = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int P       = 16;
  localparam int NFLIT   = (BODY_W + P - 1) / P;
  localparam int COORD_W = X_W + Y_W;
  localparam int LW      = NDEST * COORD_W;
  localparam int DEPTH   = 4;
  localparam int NVC     = 4;

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  vc;
    logic [1:0]  unit;
    logic [15:0] pay;
    logic [7:0]  x;
    logic [7:0]  y;
  } xf_t;

  logic              d_valid, d_hd;
  logic [1:0]        d_cls, d_unit;
  logic [NDEST-1:0]  d_mask;
  logic [LW-1:0]     d_list;
  logic [BODY_W-1:0] d_body;
  logic [NVC-1:0]    d_off;

  logic              in_full, out_valid;
  logic [1:0]        out_kind, out_vc, out_unit;
  logic [X_W-1:0]    out_x;
  logic [Y_W-1:0]    out_y;
  logic [P-1:0]      out_payload;

  int checks = 0;
  int fails  = 0;
  xf_t fq[$];
  int  mq[$];
  int  rr = 0;
  int unsigned lfsr = SEED;

  pkt_flit_injector #(
    .BODY_W(BODY_W), .PAYLOAD_W(P), .NDEST(NDEST), .X_W(X_W), .Y_W(Y_W),
    .UNIT_W(2), .DEPTH(DEPTH), .IDX_MODE(IDX_MODE), .NVC(NVC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(d_valid), .in_has_data(d_hd),
    .in_class(d_cls), .in_unit(d_unit), .in_dest_mask(d_mask),
    .in_dest_list(d_list), .in_body(d_body), .in_full(in_full),
    .vc_off(d_off), .out_valid(out_valid), .out_kind(out_kind),
    .out_vc(out_vc), .out_x(out_x), .out_y(out_y), .out_unit(out_unit),
    .out_payload(out_payload)
  );

  function automatic int unsigned rnd();
    lfsr = lfsr * 32'd1103515245 + 32'd12345;
    return lfsr >> 8;
  endfunction

  function automatic logic [15:0] chunk_of(input logic [BODY_W-1:0] b, input int i);
    logic [NFLIT*P-1:0] wide;
    wide = (NFLIT*P)'(b);
    return wide[i*P +: P];
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s (mode %0d): actual %0h expected %0h", tag, what, IDX_MODE, act, exp);
    end
  endtask

  // Expand an accepted packet into the flits it must produce
  task automatic model_accept();
    int nf, cnt, last_d, raw;
    xf_t f;
    nf  = (d_hd && NFLIT > 1) ? NFLIT : 1;
    cnt = 0;
    last_d = 0;
    for (int s = 0; s < NDEST; s++) begin
      int d;
      d = (rr + s) % NDEST;
      if (d_mask[d]) begin
        for (int i = 0; i < nf; i++) begin
          f.kind = (nf == 1) ? 2'd3 : (i == 0) ? 2'd0 : (i == nf - 1) ? 2'd2 : 2'd1;
          f.vc   = d_cls;
          f.unit = d_unit;
          f.pay  = chunk_of(d_body, i);
          if (IDX_MODE != 0) begin
            f.x = 8'(d % (1 << X_W));
            f.y = 8'((d >> X_W) % (1 << Y_W));
          end else begin
            raw = int'(d_list >> (d * COORD_W));
            f.x = 8'(raw & ((1 << X_W) - 1));
            f.y = 8'((raw >> X_W) & ((1 << Y_W) - 1));
          end
          fq.push_back(f);
          cnt++;
        end
        last_d = d;
      end
    end
    if (cnt > 0) rr = (last_d + 1) % NDEST;
    mq.push_back(cnt);
  endtask

  function automatic bit exp_valid();
    if (mq.size() == 0) return 1'b0;
    if (mq[0] == 0)     return 1'b0;
    return !d_off[fq[0].vc];
  endfunction

  task automatic check_now();
    bit ev;
    ev = exp_valid();
    chk("R10", "in_full", 64'(in_full), 64'(mq.size() == DEPTH));
    chk("R7 R8 R9", "out_valid", 64'(out_valid), 64'(ev));
    if (ev && out_valid) begin
      chk("R1 R2", "kind", 64'(out_kind), 64'(fq[0].kind));
      chk("R1 R2", "payload", 64'(out_payload), 64'(fq[0].pay));
      chk("R3", "vc", 64'(out_vc), 64'(fq[0].vc));
      chk("R3", "unit", 64'(out_unit), 64'(fq[0].unit));
      chk("R4 R5 R6", "x", 64'(out_x), 64'(fq[0].x));
      chk("R4 R5 R6", "y", 64'(out_y), 64'(fq[0].y));
    end
  endtask

  task automatic model_update();
    bit take;
    take = d_valid && (mq.size() < DEPTH);
    if (mq.size() > 0) begin
      if (mq[0] == 0) begin
        void'(mq.pop_front());
      end else if (!d_off[fq[0].vc]) begin
        void'(fq.pop_front());
        mq[0] = mq[0] - 1;
        if (mq[0] == 0) void'(mq.pop_front());
      end
    end
    if (take) model_accept();
  endtask

  task automatic step();
    #1;
    check_now();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic offer(input logic hd, input logic [1:0] cls, input logic [NDEST-1:0] m);
    d_valid = 1'b1;
    d_hd    = hd;
    d_cls   = cls;
    d_unit  = 2'(rnd());
    d_mask  = m;
    d_list  = LW'({rnd(), rnd()});
    d_body  = BODY_W'({rnd(), rnd()});
    step();
    d_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    done    = 1'b0;
    d_valid = 1'b0;
    d_hd    = 1'b0;
    d_cls   = 2'd0;
    d_unit  = 2'd0;
    d_mask  = '0;
    d_list  = '0;
    d_body  = '0;
    d_off   = '0;
    // R11: outputs quiet during reset
    forever begin
      @(negedge clk);
      if (rst_n) break;
      #1;
      chk("R11", "out_valid in reset", 64'(out_valid), 64'd0);
      chk("R11", "in_full in reset", 64'(in_full), 64'd0);
    end

    // R2 R3 R8: one destination, data packet, response class
    offer(1'b1, 2'd1, NDEST'(2));
    idle(NFLIT + 2);
    // R1: no-data packet to two destinations, service class
    offer(1'b0, 2'd3, NDEST'(5));
    idle(4);
    // R4 R5 R6: every destination, request class
    offer(1'b1, 2'd0, '1);
    idle(NDEST * NFLIT + 2);
    // R7: stall before and inside a sequence; other channel off has no effect
    d_off = 4'b0100;
    offer(1'b1, 2'd2, NDEST'(9));
    idle(2);
    d_off = 4'b0001;
    step();
    d_off = 4'b0101;
    idle(3);
    d_off = 4'b0000;
    step();
    d_off = 4'b0100;
    idle(2);
    d_off = 4'b0000;
    idle(2 * NFLIT + 2);
    // R9: empty mask followed at once by a normal packet
    offer(1'b1, 2'd1, '0);
    offer(1'b0, 2'd1, NDEST'(8));
    idle(4);
    // R10: fill while blocked, keep offering across the first pop
    d_off = 4'b1111;
    for (int i = 0; i < DEPTH + 2; i++) begin
      d_valid = 1'b1; d_hd = 1'b0; d_cls = 2'(i); d_unit = 2'(i);
      d_mask = NDEST'(1) << (i % NDEST);
      d_list = LW'({rnd(), rnd()}); d_body = BODY_W'({rnd(), rnd()});
      step();
    end
    d_off = 4'b0000;
    for (int i = 0; i < 4; i++) begin
      d_body = BODY_W'({rnd(), rnd()});
      step();
    end
    d_valid = 1'b0;
    idle(DEPTH * NDEST * NFLIT + 4);
    // Mixed traffic: all requirements under random patterns
    for (int c = 0; c < 600; c++) begin
      d_valid = (rnd() % 2) == 0;
      d_hd    = (rnd() % 3) != 0;
      d_cls   = 2'(rnd());
      d_unit  = 2'(rnd());
      d_mask  = NDEST'(rnd());
      d_list  = LW'({rnd(), rnd()});
      d_body  = BODY_W'({rnd(), rnd()});
      for (int b = 0; b < NVC; b++) d_off[b] = (rnd() % 8) == 0;
      step();
    end
    d_valid = 1'b0;
    d_off   = '0;
    idle(DEPTH * NDEST * NFLIT + 8);
    chk("R8", "model drained", 64'(mq.size()), 64'd0);
    done = 1'b1;
  end
endmodule

// File: tb/sim_pkt_flit_injector.sv
module sim_pkt_flit_injector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic done_a, done_b;

  always #10 clk = ~clk;

  sim_inj_lane #(.IDX_MODE(0), .NDEST(4), .X_W(2), .Y_W(2), .BODY_W(40), .SEED(7)) la (
    .clk(clk), .rst_n(rst_n), .done(done_a)
  );

  sim_inj_lane #(.IDX_MODE(1), .NDEST(8), .X_W(2), .Y_W(1), .BODY_W(32), .SEED(99)) lb (
    .clk(clk), .rst_n(rst_n), .done(done_b)
  );

  initial begin
    int cyc;
    int extra_chk;
    int extra_fail;
    cyc = 0;
    extra_chk = 0;
    extra_fail = 0;
    #45 rst_n = 1'b1;
    while (!(done_a === 1'b1 && done_b === 1'b1) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    extra_chk = 1;
    if (!(done_a === 1'b1 && done_b === 1'b1)) begin
      extra_fail = 1;
      $display("FAIL watchdog: run did not complete, actual cycles %0d expected fewer than %0d",
               cyc, 100000);
    end
    #5;
    $display("End of test - %0d assertions evaluated, %0d failures",
             la.checks + lb.checks + extra_chk, la.fails + lb.fails + extra_fail);
    $finish;
  end
endmodule